// File: doc/BRIEF.md
# Free-Running Match Timer

A memory-mapped timer built around a 32-bit up-counter that runs freely while enabled and wraps from all ones to zero. One compare register is checked against the running count. A match sets a sticky status flag, and that flag drives an interrupt output when the interrupt is enabled.

The count is not read directly. Software first writes the control register with the request bit set. It then polls a busy flag in the access-status register, and once the flag drops it reads a stable copy of the count. Writes to the compare register and writes that preload the counter follow the same pattern. Each is held pending for a fixed number of cycles, with its own busy flag, before it takes effect. This models a counter that lives in another clock domain. The bus is a plain single-cycle write strobe with a combinational read port.

Top module: `match_timer`

## Requirements
- R1: After reset the counter, snapshot, status, interrupt enable, control and access status all read 0, the match register (offset 0x00) reads 0xFFFFFFFF, and `irq` is low.
- R2: While control bit 0 (offset 0x20) is 1 the counter adds one on every clock edge and wraps from 0xFFFFFFFF to 0. While that bit is 0 the counter holds its value.
- R3: A control write with bit 1 set requests a snapshot, so writing 3 both enables counting and requests a snapshot. Access-status bit 5 (offset 0x24) is then high for exactly two cycles. Once it falls, offset 0x10 reads the count from the last busy cycle. A request made while bit 5 is high is ignored.
- R4: A write to offset 0x00 raises access-status bit 0 for exactly two cycles. The old match value stays readable during that time, and the new value takes effect when the flag falls. A match write made while bit 0 is high is ignored.
- R5: A write to offset 0x10 raises access-status bit 4 for exactly two cycles, and the counter is then loaded with the written value. A count write made while bit 4 is high is ignored.
- R6: Status bit 0 (offset 0x14) becomes 1 on the edge where counting is enabled and the count equals the match value. It stays 1 until software clears it.
- R7: Status bits are write-one-to-clear. Writing 1 to bit 0 clears it and writing 0 leaves it alone. A match in the same cycle as the clear wins, and bits 3:1 always read 0.
- R8: `irq` is high exactly when status bit 0 and interrupt-enable bit 0 (offset 0x1C) are both 1.
- R9: Reads of offsets other than 0x00, 0x10, 0x14, 0x1C, 0x20 and 0x24 return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Match interrupt |

## Verification
The bench first sweeps every word offset in the address space. This separates the six decoded registers from the holes, and shows that writes to the holes leave every real register untouched. Snapshot requests are repeated while the counter crosses the wrap point, and one is made with counting stopped, so a wrong capture cycle, a missed wrap or an increment while disabled each give a distinct wrong value. Several match values at different distances from the count are written while a lockout write is attempted, and status and `irq` are compared every cycle against an arithmetic model. This exposes an early compare, a missing lockout, a lost sticky bit or a wrong enable gate.

// File: rtl/match_timer.sv
module match_timer #(
  parameter int AW       = 6,
  parameter int DW       = 32,
  parameter int SYNC_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);
  localparam int SW = $clog2(SYNC_CYC + 1);
  localparam logic [SW-1:0] SYNC_LD = SW'(SYNC_CYC);
  localparam logic [SW-1:0] ONE = SW'(1);
  localparam logic [AW-1:0] A_MATCH = AW'('h00);
  localparam logic [AW-1:0] A_COUNT = AW'('h10);
  localparam logic [AW-1:0] A_STAT  = AW'('h14);
  localparam logic [AW-1:0] A_IEN   = AW'('h1C);
  localparam logic [AW-1:0] A_CTRL  = AW'('h20);
  localparam logic [AW-1:0] A_BUSY  = AW'('h24);

  logic [DW-1:0] cnt, match, snap, match_nx, load_nx;
  logic [SW-1:0] snap_cd, match_cd, load_cd;
  logic          run, ien, hit;

  wire snap_busy  = snap_cd  != '0;
  wire match_busy = match_cd != '0;
  wire load_busy  = load_cd  != '0;
  wire wr_match   = bus_wr && bus_addr == A_MATCH;
  wire wr_count   = bus_wr && bus_addr == A_COUNT;
  wire wr_stat    = bus_wr && bus_addr == A_STAT;
  wire wr_ien     = bus_wr && bus_addr == A_IEN;
  wire wr_ctrl    = bus_wr && bus_addr == A_CTRL;
  wire load_done  = load_cd == ONE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
      load_cd <= '0;
      load_nx <= '0;
    end else begin
      if (load_done)   cnt <= load_nx;
      else if (run)    cnt <= cnt + 1'b1;
      if (load_busy)   load_cd <= load_cd - 1'b1;
      else if (wr_count) begin
        load_cd <= SYNC_LD;
        load_nx <= bus_wdata;
      end
      if (wr_ctrl) run <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_cd <= '0;
      snap <= '0;
    end else if (snap_busy) begin
      snap_cd <= snap_cd - 1'b1;
      if (snap_cd == ONE) snap <= cnt;
    end else if (wr_ctrl && bus_wdata[1]) begin
      snap_cd <= SYNC_LD;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_cd <= '0;
      match <= '1;
      match_nx <= '0;
    end else if (match_busy) begin
      match_cd <= match_cd - 1'b1;
      if (match_cd == ONE) match <= match_nx;
    end else if (wr_match) begin
      match_cd <= SYNC_LD;
      match_nx <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit <= 1'b0;
      ien <= 1'b0;
    end else begin
      if (run && cnt == match)          hit <= 1'b1;
      else if (wr_stat && bus_wdata[0]) hit <= 1'b0;
      if (wr_ien) ien <= bus_wdata[0];
    end
  end

  assign irq = hit & ien;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_MATCH: bus_rdata = match;
      A_COUNT: bus_rdata = snap;
      A_STAT:  bus_rdata[0] = hit;
      A_IEN:   bus_rdata[0] = ien;
      A_CTRL:  bus_rdata[0] = run;
      A_BUSY:  begin
        bus_rdata[5] = snap_busy;
        bus_rdata[4] = load_busy;
        bus_rdata[0] = match_busy;
      end
      default: bus_rdata = '0;
    endcase
  end

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run && !load_done |=> cnt == $past(cnt) + 1'b1);
  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !load_busy |=> $stable(cnt));
  assert_snap_busy_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(snap_busy) |=> snap_busy);
  assert_match_lockout_R4: assert property (@(posedge clk) disable iff (!rst_n)
    match_busy && wr_match |=> match_nx == $past(match_nx));
  assert_load_lockout_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_busy && wr_count |=> load_nx == $past(load_nx));
  assert_hit_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hit) |-> $past(run && cnt == match));
  assert_hit_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !(wr_stat && bus_wdata[0]) |=> hit);
  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> hit && ien);
endmodule

// File: tb/sim_match_timer.sv
module sim_match_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  match_timer u0 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
                  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  always #5 clk = ~clk;

  // reference model written from the requirements
  logic [31:0] m_cnt, m_match, m_snap, m_mval, m_lval;
  logic [1:0]  m_scd, m_mcd, m_lcd;
  logic        m_run, m_ien, m_hit;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt <= 0; m_match <= '1; m_snap <= 0; m_mval <= 0; m_lval <= 0;
      m_scd <= 0; m_mcd <= 0; m_lcd <= 0; m_run <= 0; m_ien <= 0; m_hit <= 0;
    end else begin
      if (m_lcd == 1) m_cnt <= m_lval;
      else if (m_run) m_cnt <= m_cnt + 1;
      if (m_run && m_cnt == m_match) m_hit <= 1;
      else if (bus_wr && bus_addr == 6'h14 && bus_wdata[0]) m_hit <= 0;
      if (m_lcd != 0) m_lcd <= m_lcd - 1;
      else if (bus_wr && bus_addr == 6'h10) begin m_lcd <= 2; m_lval <= bus_wdata; end
      if (m_mcd != 0) begin
        m_mcd <= m_mcd - 1;
        if (m_mcd == 1) m_match <= m_mval;
      end else if (bus_wr && bus_addr == 6'h00) begin m_mcd <= 2; m_mval <= bus_wdata; end
      if (m_scd != 0) begin
        m_scd <= m_scd - 1;
        if (m_scd == 1) m_snap <= m_cnt;
      end else if (bus_wr && bus_addr == 6'h20 && bus_wdata[1]) m_scd <= 2;
      if (bus_wr && bus_addr == 6'h20) m_run <= bus_wdata[0];
      if (bus_wr && bus_addr == 6'h1C) m_ien <= bus_wdata[0];
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic snap_check(input logic [31:0] ctrl_val, input string tag);
    logic [31:0] exp;
    wr(6'h20, ctrl_val);
    rd(6'h24, 32'h20, tag);
    @(negedge clk);
    rd(6'h24, 32'h20, tag);
    exp = m_cnt;
    @(negedge clk);
    rd(6'h24, 32'h0, tag);
    rd(6'h10, exp, tag);
  endtask

  task automatic monitor(input int cycles, input string tag);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      rd(6'h14, {31'b0, m_hit}, tag);
      check(tag, {31'b0, irq}, {31'b0, m_hit & m_ien});
    end
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(6'h00, 32'hFFFFFFFF, "R1 match");
    rd(6'h10, 0, "R1 count");
    rd(6'h14, 0, "R1 status");
    rd(6'h1C, 0, "R1 ien");
    rd(6'h20, 0, "R1 ctrl");
    rd(6'h24, 0, "R1 busy");
    check("R1 irq", {31'b0, irq}, 0);
    // R9 sweep of undefined word offsets
    for (int a = 0; a < 64; a += 4) begin
      if (a != 'h00 && a != 'h10 && a != 'h14 && a != 'h1C && a != 'h20 && a != 'h24) begin
        rd(6'(a), 0, "R9 hole read");
        wr(6'(a), 32'hFFFFFFFF);
      end
    end
    rd(6'h00, 32'hFFFFFFFF, "R9 match kept");
    rd(6'h1C, 0, "R9 ien kept");
    rd(6'h20, 0, "R9 ctrl kept");
    rd(6'h24, 0, "R9 nothing pending");
    // R5 counter preload with lockout
    wr(6'h10, 32'hFFFFFFF0);
    rd(6'h24, 32'h10, "R5 busy 1");
    wr(6'h10, 32'h12345678);
    rd(6'h24, 32'h10, "R5 busy 2");
    @(negedge clk);
    rd(6'h24, 0, "R5 busy clear");
    // R3 snapshot with counting stopped, R2 hold
    snap_check(32'h2, "R3 stopped snapshot");
    rd(6'h10, 32'hFFFFFFF0, "R5 loaded value");
    rd(6'h20, 0, "R2 still stopped");
    // R2 wrap via repeated snapshots
    wr(6'h20, 32'h1);
    for (int i = 0; i < 12; i++) snap_check(32'h3, "R2 R3 running snapshot");
    check("R2 wrapped", {31'b0, m_cnt < 32'h100}, 1);
    // R3 request during busy ignored
    wr(6'h20, 32'h3);
    wr(6'h20, 32'h3);
    rd(6'h24, 32'h20, "R3 busy 2");
    @(negedge clk);
    rd(6'h24, 0, "R3 no re-trigger");
    // R4 match write with lockout
    wr(6'h00, m_cnt + 40);
    rd(6'h24, 32'h1, "R4 busy 1");
    rd(6'h00, 32'hFFFFFFFF, "R4 old value");
    wr(6'h00, 32'h0);
    rd(6'h24, 32'h1, "R4 busy 2");
    @(negedge clk);
    rd(6'h24, 0, "R4 busy clear");
    rd(6'h00, m_match, "R4 new value");
    // R6 R8 compare, sticky status, interrupt
    wr(6'h1C, 32'h1);
    monitor(50, "R6 R8 match");
    rd(6'h14, 1, "R6 sticky");
    // R7 write-one-to-clear
    wr(6'h14, 32'hE);
    rd(6'h14, 1, "R7 zero write keeps");
    wr(6'h14, 32'hF);
    rd(6'h14, 0, "R7 cleared");
    // sweep of match distances, with and without enable
    for (int k = 0; k < 6; k++) begin
      wr(6'h1C, {31'b0, k[0]});
      wr(6'h14, 32'h1);
      wr(6'h00, m_cnt + 6 + k);
      monitor(16, "R6 R8 sweep");
    end
    // R7 set wins over clear in the same cycle
    wr(6'h00, m_cnt + 4);
    while (m_cnt != m_match) @(negedge clk);
    wr(6'h14, 32'h1);
    rd(6'h14, 1, "R7 set wins");
    // R2 stop holds count
    wr(6'h20, 32'h0);
    snap_check(32'h2, "R2 stopped hold");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule